// File: doc/BRIEF.md
# Serial Configuration Image Loader

This block is a hardware master that pushes a configuration image into a target programmable device that waits in slave serial mode. It owns the target's active-low reset line, its active-low chip-select line, and a serial clock and data pair. It watches the target's configuration-complete input. The image arrives as a stream of bytes over a valid/ready handshake, and the last byte is flagged with `s_last`.

A one-cycle `start` pulse launches a full sequence. The block asserts reset, then asserts chip-select, and holds both for a programmable time. It then verifies that the target reports "not configured" and releases reset. After a programmable settling wait it raises chip-select and sends a programmable run of dummy clocks. Next it lowers chip-select and shifts the whole image out MSB first. It raises chip-select again, sends a second programmable run of dummy clocks, and finally samples the completion input. A CRC-32 of the streamed bytes is accumulated along the way. That CRC is presented, together with a success flag, only when the target reports completion. In every other case the error flag is raised.

The serial clock idles low. Data changes while the clock is low and is sampled by the target on the rising edge. Each clock phase lasts `CLK_HALF` system cycles.

Top module: `cfg_loader`

## Requirements
- R1: A `start` pulse while idle raises `busy` and drives `tgt_rst_n` low on the next clock edge while `tgt_cs_n` stays high. `tgt_cs_n` goes low one cycle later. The reset line falls exactly once per load.
- R2: `tgt_rst_n` stays low for exactly max(`cfg_rst_hold`, `MIN_RST_CYCLES`) + 2 cycles, and chip-select is low during the hold.
- R3: If `tgt_done` is high at the last cycle of the reset hold, the load ends with `load_err` = 1. No serial clock is issued and no image byte is accepted.
- R4: After reset is released, chip-select stays low for exactly `cfg_post_wait` + 1 cycles before it rises.
- R5: Exactly `cfg_lead_clks` rising serial clock edges occur with chip-select high before the payload begins, and none occurs while reset is low.
- R6: Every image byte is shifted out MSB first, with chip-select held low for the whole payload. `s_ready` is only high while chip-select is low and reset is released. The data line does not change while the serial clock is high.
- R7: Exactly `cfg_trail_clks` rising serial clock edges occur with chip-select high after the payload.
- R8: After the trailing clocks, `tgt_done` = 1 gives `load_ok` = 1 and `tgt_done` = 0 gives `load_err` = 1. The two flags are never high together.
- R9: When `busy` falls, both `tgt_rst_n` and `tgt_cs_n` are high. This holds on success and on every error exit.
- R10: On success, `image_crc` carries the reflected CRC-32 (polynomial 0xEDB88320, initial value all ones, final inversion) of the streamed bytes, for example 0xCBF43926 for the ASCII bytes "123456789". `image_crc` reads 0 whenever `load_ok` is 0.
- R11: A `start` pulse while `busy` has no effect. A new load clears `load_ok`, `load_err` and `image_crc` on the cycle `busy` rises.
- R12: Every high phase of `tgt_sclk` lasts exactly `CLK_HALF` system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block |
| start | input | 1 | One-cycle request to begin a load |
| cfg_rst_hold | input | CNT_W | Requested reset hold length in cycles (floored at MIN_RST_CYCLES) |
| cfg_post_wait | input | CNT_W | Cycles to wait after reset release before raising chip-select |
| cfg_lead_clks | input | CNT_W | Number of dummy clocks before the payload |
| cfg_trail_clks | input | CNT_W | Number of dummy clocks after the payload |
| s_data | input | 8 | Image byte |
| s_valid | input | 1 | Image byte valid |
| s_last | input | 1 | Marks the final image byte |
| s_ready | output | 1 | Block accepts the image byte this cycle |
| tgt_rst_n | output | 1 | Target reset, active low |
| tgt_cs_n | output | 1 | Target chip-select, active low |
| tgt_sclk | output | 1 | Serial clock, idles low |
| tgt_sdo | output | 1 | Serial data to the target |
| tgt_done | input | 1 | Target configuration-complete indication |
| busy | output | 1 | A load sequence is in progress |
| load_ok | output | 1 | Last load completed and the target reported done |
| load_err | output | 1 | Last load aborted or the target did not report done |
| image_crc | output | 32 | CRC-32 of the loaded image, valid with load_ok |

## Verification
`busy`, `tgt_rst_n` and the cleared status flags respond one edge after `start`, and `tgt_cs_n` falls one edge later. The bench samples each of these at the falling clock edge that follows the edge concerned. Durations of the reset hold, the post-release wait and each serial clock high phase are measured by a falling-edge monitor as exact cycle counts, and the monitor compares them with max(hold, minimum) + 2, wait + 1 and `CLK_HALF`. Completion flags and the CRC settle on the edge where `busy` falls, so they are read at the first falling edge with `busy` low. Bytes and dummy clocks are reconstructed from rising serial clock edges, which are classified by the chip-select and phase seen at that moment.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RST,
    ST_HOLD,
    ST_POST,
    ST_LEAD,
    ST_DATA,
    ST_TRAIL
  } seq_state_e;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED      = 32'hFFFF_FFFF;

  // One byte of the reflected CRC-32 update, LSB of the byte first.
  function automatic logic [31:0] crc32_step(input logic [31:0] c_in,
                                             input logic [7:0]  b);
    logic [31:0] c;
    c = c_in ^ {24'd0, b};
    for (int i = 0; i < 8; i++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
    end
    return c;
  endfunction

  // Raise a requested count to a floor value.
  function automatic logic [31:0] floor_at(input logic [31:0] req,
                                           input logic [31:0] floor_v);
    return (req < floor_v) ? floor_v : req;
  endfunction

endpackage

// File: rtl/cfgl_serial.sv
module cfgl_serial #(
  parameter int HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [3:0] nbits,
  input  logic [7:0] data,
  output logic       idle,
  output logic       sclk,
  output logic       sdo
);
  localparam int PW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [PW-1:0] PH_LOAD = PW'(HALF - 1);

  logic          run_q;
  logic          hi_q;
  logic [PW-1:0] ph_q;
  logic [3:0]    left_q;
  logic [7:0]    sr_q;
  logic          sclk_q;

  // Named events for the checks.
  logic phase_end;
  logic bit_end;
  assign phase_end = run_q && (ph_q == '0);
  assign bit_end   = phase_end && hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      hi_q   <= 1'b0;
      ph_q   <= '0;
      left_q <= '0;
      sr_q   <= '0;
      sclk_q <= 1'b0;
    end else if (!run_q) begin
      if (go) begin
        run_q  <= 1'b1;
        hi_q   <= 1'b0;
        ph_q   <= PH_LOAD;
        left_q <= nbits;
        sr_q   <= data;
        sclk_q <= 1'b0;
      end
    end else if (!phase_end) begin
      ph_q <= ph_q - 1'b1;
    end else if (!hi_q) begin
      hi_q   <= 1'b1;
      sclk_q <= 1'b1;
      ph_q   <= PH_LOAD;
    end else begin
      sclk_q <= 1'b0;
      hi_q   <= 1'b0;
      ph_q   <= PH_LOAD;
      if (left_q <= 4'd1) begin
        run_q <= 1'b0;
      end else begin
        left_q <= left_q - 1'b1;
        sr_q   <= {sr_q[6:0], 1'b0};
      end
    end
  end

  assign idle = !run_q;
  assign sclk = sclk_q;
  assign sdo  = sr_q[7];

  // R6: data only moves while the serial clock is low.
  a_r6_sdo_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_q |-> $stable(sr_q[7]));

  // R12: a high phase ends only at a counted phase boundary.
  a_r12_fall_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_q) |-> $past(bit_end));

  // R12: the clock never toggles while the engine is idle.
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !go) |=> !sclk_q);

endmodule

// File: rtl/cfgl_crc32.sv
module cfgl_crc32 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] crc
);
  import cfgl_pkg::*;

  logic [31:0] acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc_q <= CRC_SEED;
    else if (clr) acc_q <= CRC_SEED;
    else if (en)  acc_q <= crc32_step(acc_q, din);
  end

  assign crc = ~acc_q;

  // R10: a clear always returns the accumulator to the seed.
  a_r10_clear_seed: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (crc == 32'd0));

endmodule

// File: rtl/cfg_loader.sv
module cfg_loader #(
  parameter int CLK_HALF       = 2,
  parameter int CNT_W          = 16,
  parameter int MIN_RST_CYCLES = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] cfg_rst_hold,
  input  logic [CNT_W-1:0] cfg_post_wait,
  input  logic [CNT_W-1:0] cfg_lead_clks,
  input  logic [CNT_W-1:0] cfg_trail_clks,
  input  logic [7:0]       s_data,
  input  logic             s_valid,
  input  logic             s_last,
  output logic             s_ready,
  output logic             tgt_rst_n,
  output logic             tgt_cs_n,
  output logic             tgt_sclk,
  output logic             tgt_sdo,
  input  logic             tgt_done,
  output logic             busy,
  output logic             load_ok,
  output logic             load_err,
  output logic [31:0]      image_crc
);
  import cfgl_pkg::*;

  localparam logic [31:0] MIN_HOLD = 32'(MIN_RST_CYCLES);

  seq_state_e       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rst_q, cs_q;
  logic             ok_q, err_q;
  logic             last_seen_q;

  logic             eng_idle, eng_go;
  logic [3:0]       eng_nbits;
  logic [7:0]       eng_data;
  logic [31:0]      crc_val;

  // Named internal events.
  logic launch, hold_end, s_hs, pay_end, trail_end, cnt_zero, busy_w;
  assign busy_w    = (st_q != ST_IDLE);
  assign cnt_zero  = (cnt_q == '0);
  assign launch    = (st_q == ST_IDLE) && start;
  assign hold_end  = (st_q == ST_HOLD) && cnt_zero;
  assign s_ready   = (st_q == ST_DATA) && eng_idle && !last_seen_q;
  assign s_hs      = s_ready && s_valid;
  assign pay_end   = (st_q == ST_DATA) && eng_idle && last_seen_q;
  assign trail_end = (st_q == ST_TRAIL) && eng_idle && cnt_zero;

  always_comb begin
    eng_go    = 1'b0;
    eng_nbits = 4'd8;
    eng_data  = s_data;
    case (st_q)
      ST_LEAD, ST_TRAIL: begin
        if (eng_idle && !cnt_zero) begin
          eng_go    = 1'b1;
          eng_nbits = 4'd1;
          eng_data  = 8'hFF;
        end
      end
      ST_DATA: eng_go = s_hs;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      cnt_q       <= '0;
      rst_q       <= 1'b1;
      cs_q        <= 1'b1;
      ok_q        <= 1'b0;
      err_q       <= 1'b0;
      last_seen_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            st_q  <= ST_RST;
            rst_q <= 1'b0;
            ok_q  <= 1'b0;
            err_q <= 1'b0;
          end
        end
        ST_RST: begin
          st_q  <= ST_HOLD;
          cs_q  <= 1'b0;
          cnt_q <= CNT_W'(floor_at(32'(cfg_rst_hold), MIN_HOLD));
        end
        ST_HOLD: begin
          if (!cnt_zero) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (tgt_done) begin
            st_q  <= ST_IDLE;
            err_q <= 1'b1;
            rst_q <= 1'b1;
            cs_q  <= 1'b1;
          end else begin
            st_q  <= ST_POST;
            rst_q <= 1'b1;
            cnt_q <= cfg_post_wait;
          end
        end
        ST_POST: begin
          if (!cnt_zero) begin
            cnt_q <= cnt_q - 1'b1;
          end else begin
            st_q  <= ST_LEAD;
            cs_q  <= 1'b1;
            cnt_q <= cfg_lead_clks;
          end
        end
        ST_LEAD: begin
          if (eng_idle) begin
            if (cnt_zero) begin
              st_q <= ST_DATA;
              cs_q <= 1'b0;
            end else begin
              cnt_q <= cnt_q - 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (s_hs && s_last) last_seen_q <= 1'b1;
          if (pay_end) begin
            st_q        <= ST_TRAIL;
            cs_q        <= 1'b1;
            cnt_q       <= cfg_trail_clks;
            last_seen_q <= 1'b0;
          end
        end
        ST_TRAIL: begin
          if (eng_idle) begin
            if (cnt_zero) begin
              st_q  <= ST_IDLE;
              ok_q  <= tgt_done;
              err_q <= !tgt_done;
            end else begin
              cnt_q <= cnt_q - 1'b1;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  cfgl_serial #(.HALF(CLK_HALF)) u_serial (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (eng_go),
    .nbits (eng_nbits),
    .data  (eng_data),
    .idle  (eng_idle),
    .sclk  (tgt_sclk),
    .sdo   (tgt_sdo)
  );

  cfgl_crc32 u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (launch),
    .en    (s_hs),
    .din   (s_data),
    .crc   (crc_val)
  );

  assign tgt_rst_n = rst_q;
  assign tgt_cs_n  = cs_q;
  assign busy      = busy_w;
  assign load_ok   = ok_q;
  assign load_err  = err_q;
  assign image_crc = ok_q ? crc_val : 32'd0;

  // R1: reset falls while chip-select is still released.
  a_r1_rst_before_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tgt_rst_n) |-> tgt_cs_n);

  // R1: chip-select only falls under reset after reset was already low.
  a_r1_cs_follows_rst: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(tgt_cs_n) && !tgt_rst_n) |-> !$past(tgt_rst_n));

  // R2: both lines are asserted when the hold ends.
  a_r2_hold_lines: assert property (@(posedge clk) disable iff (!rst_n)
    hold_end |-> (!tgt_rst_n && !tgt_cs_n));

  // R5: no serial clock while the target is in reset.
  a_r5_no_clock_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_rst_n |-> !tgt_sclk);

  // R6: the byte window only opens with chip-select low and reset released.
  a_r6_ready_window: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (!tgt_cs_n && tgt_rst_n));

  // R8: success and failure are exclusive.
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_ok && load_err));

  // R9: every exit leaves the target lines released.
  a_r9_release_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (tgt_rst_n && tgt_cs_n));

  // R11: a new load clears the status flags.
  a_r11_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!load_ok && !load_err));

endmodule

// File: tb/tb_cfg_loader.sv
module tb_cfg_loader;
  localparam int HALF  = 2;
  localparam int CW    = 16;
  localparam int MINR  = 25;
  localparam logic [31:0] POLY = 32'hEDB88320;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [CW-1:0] cfg_rst_hold = '0, cfg_post_wait = '0, cfg_lead_clks = '0, cfg_trail_clks = '0;
  logic [7:0] s_data = '0;
  logic s_valid = 1'b0, s_last = 1'b0;
  logic s_ready, tgt_rst_n, tgt_cs_n, tgt_sclk, tgt_sdo;
  logic tgt_done = 1'b0;
  logic busy, load_ok, load_err;
  logic [31:0] image_crc;

  cfg_loader #(.CLK_HALF(HALF), .CNT_W(CW), .MIN_RST_CYCLES(MINR)) dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_rst_hold(cfg_rst_hold), .cfg_post_wait(cfg_post_wait),
    .cfg_lead_clks(cfg_lead_clks), .cfg_trail_clks(cfg_trail_clks),
    .s_data(s_data), .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready),
    .tgt_rst_n(tgt_rst_n), .tgt_cs_n(tgt_cs_n), .tgt_sclk(tgt_sclk), .tgt_sdo(tgt_sdo),
    .tgt_done(tgt_done), .busy(busy), .load_ok(load_ok), .load_err(load_err),
    .image_crc(image_crc)
  );

  always #4 clk = ~clk;

  int pass_cnt = 0;
  int fail_cnt = 0;

  task automatic chk(input bit cond, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    if (cond) pass_cnt++;
    else begin
      fail_cnt++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Source of image bytes.
  logic [7:0] tx [0:63];
  int tx_n = 0, tx_idx = 0;
  bit hs_pend = 0;
  always @(negedge clk) begin
    if (hs_pend) tx_idx++;
    if (tx_idx < tx_n) begin
      s_valid = 1'b1;
      s_data  = tx[tx_idx];
      s_last  = (tx_idx == tx_n - 1);
      hs_pend = s_ready;
    end else begin
      s_valid = 1'b0;
      s_last  = 1'b0;
      hs_pend = 0;
    end
  end

  // Target model and line monitor.
  logic [7:0] rx [0:63];
  int rx_n, nb, rst_low, rst_falls, post_cyc, lead_cnt, trail_cnt, hi_run, hi_bad;
  bit lead_seen, pay_seen, mon_clr = 0;
  bit prev_sclk = 0, prev_rst = 1;
  logic [7:0] cur;
  int dmode = 0;
  always @(negedge clk) begin
    if (mon_clr) begin
      rx_n = 0; nb = 0; rst_low = 0; rst_falls = 0; post_cyc = 0;
      lead_cnt = 0; trail_cnt = 0; hi_run = 0; hi_bad = 0;
      lead_seen = 0; pay_seen = 0; cur = 8'd0; mon_clr = 0;
    end else begin
      if (!tgt_rst_n) rst_low++;
      if (prev_rst && !tgt_rst_n) rst_falls++;
      if (tgt_rst_n && !tgt_cs_n && rst_falls > 0 && !lead_seen) post_cyc++;
      if (tgt_rst_n && tgt_cs_n && rst_falls > 0 && post_cyc > 0) lead_seen = 1;
      if (tgt_rst_n && !tgt_cs_n && lead_seen) pay_seen = 1;
      if (!prev_sclk && tgt_sclk) begin
        if (tgt_cs_n) begin
          if (pay_seen) trail_cnt++; else lead_cnt++;
        end else begin
          cur = {cur[6:0], tgt_sdo};
          nb++;
          if (nb == 8) begin
            if (rx_n < 64) rx[rx_n] = cur;
            rx_n++;
            nb = 0;
          end
        end
      end
      if (tgt_sclk) hi_run++;
      else if (prev_sclk) begin
        if (hi_run != HALF) hi_bad++;
        hi_run = 0;
      end
    end
    prev_sclk = tgt_sclk;
    prev_rst  = tgt_rst_n;
    case (dmode)
      1: tgt_done = 1'b1;
      2: tgt_done = 1'b0;
      default: tgt_done = pay_seen && tgt_cs_n;
    endcase
  end

  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] r = 32'hFFFF_FFFF;
    for (int k = 0; k < n; k++) begin
      for (int j = 0; j < 8; j++) begin
        logic fb;
        fb = r[0] ^ tx[k][j];
        r = r >> 1;
        if (fb) r = r ^ POLY;
      end
    end
    return ~r;
  endfunction

  // mode: 0 target completes, 1 done stuck high, 2 done never rises
  task automatic run_load(input string name, input int n, input int lead, input int trail,
                          input int rh, input int pw, input int mode, input bit poke,
                          input bit ascii);
    int exp_low, mism, guard;
    logic [31:0] exp_crc;
    for (int i = 0; i < n; i++) tx[i] = ascii ? 8'(8'h31 + i) : 8'(i * 37 + 8'h5A);
    exp_crc = ref_crc(n);
    exp_low = ((rh < MINR) ? MINR : rh) + 2;
    @(negedge clk);
    dmode = mode;
    mon_clr = 1;
    cfg_rst_hold = CW'(rh); cfg_post_wait = CW'(pw);
    cfg_lead_clks = CW'(lead); cfg_trail_clks = CW'(trail);
    tx_idx = 0; tx_n = n;
    @(negedge clk);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R1", {name, " busy after start"}, 32'(busy), 1);
    chk(tgt_rst_n == 1'b0 && tgt_cs_n == 1'b1, "R1", {name, " reset first"},
        {30'd0, tgt_rst_n, tgt_cs_n}, 32'd1);
    chk(load_ok == 1'b0 && load_err == 1'b0 && image_crc == 32'd0, "R11",
        {name, " status cleared"}, image_crc, 0);
    @(negedge clk);
    chk(tgt_cs_n == 1'b0, "R1", {name, " cs after reset"}, 32'(tgt_cs_n), 0);
    if (poke) begin
      repeat (40) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (busy && guard < 50000) begin
      @(negedge clk);
      guard++;
    end
    chk(!busy, "R8", {name, " finished"}, 32'(busy), 0);
    chk(rst_low == exp_low, "R2", {name, " reset low cycles"}, 32'(rst_low), 32'(exp_low));
    chk(tgt_rst_n && tgt_cs_n, "R9", {name, " lines released"},
        {30'd0, tgt_rst_n, tgt_cs_n}, 32'd3);
    if (mode == 1) begin
      chk(load_err && !load_ok, "R3", {name, " error on early done"}, {30'd0, load_ok, load_err}, 1);
      chk(lead_cnt + trail_cnt + rx_n + nb == 0, "R3", {name, " no clocks"},
          32'(lead_cnt + trail_cnt + rx_n + nb), 0);
      chk(tx_idx == 0, "R3", {name, " no bytes taken"}, 32'(tx_idx), 0);
      chk(image_crc == 32'd0, "R10", {name, " crc hidden"}, image_crc, 0);
    end else begin
      mism = 0;
      for (int i = 0; i < n; i++) if (rx[i] != tx[i]) mism++;
      chk(rx_n == n && nb == 0, "R6", {name, " byte count"}, 32'(rx_n), 32'(n));
      chk(mism == 0, "R6", {name, " byte values msb first"}, 32'(mism), 0);
      chk(post_cyc == pw + 1, "R4", {name, " post wait"}, 32'(post_cyc), 32'(pw + 1));
      chk(lead_cnt == lead, "R5", {name, " leading clocks"}, 32'(lead_cnt), 32'(lead));
      chk(trail_cnt == trail, "R7", {name, " trailing clocks"}, 32'(trail_cnt), 32'(trail));
      chk(hi_bad == 0, "R12", {name, " clock high phase"}, 32'(hi_bad), 0);
      chk(rst_falls == 1, "R11", {name, " single reset pulse"}, 32'(rst_falls), 1);
      if (mode == 0) begin
        chk(load_ok && !load_err, "R8", {name, " success"}, {30'd0, load_ok, load_err}, 2);
        chk(image_crc == exp_crc, "R10", {name, " crc"}, image_crc, exp_crc);
      end else begin
        chk(load_err && !load_ok, "R8", {name, " missing done"}, {30'd0, load_ok, load_err}, 1);
        chk(image_crc == 32'd0, "R10", {name, " crc hidden on error"}, image_crc, 0);
      end
    end
  endtask

  bit finished = 0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fail_cnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
      $finish;
    end
  end

  initial begin
    mon_clr = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state
    chk(!busy && !load_ok && !load_err, "R9", "reset status", {29'd0, busy, load_ok, load_err}, 0);
    chk(tgt_rst_n && tgt_cs_n && !tgt_sclk, "R9", "reset lines",
        {29'd0, tgt_rst_n, tgt_cs_n, tgt_sclk}, 32'd6);
    chk(!s_ready && image_crc == 32'd0, "R10", "reset crc", image_crc, 0);

    run_load("ascii", 9, 8, 49, 30, 10, 0, 0, 1);
    chk(image_crc == 32'hCBF43926, "R10", "check value", image_crc, 32'hCBF43926);
    run_load("floor", 1, 0, 0, 3, 0, 0, 0, 0);
    run_load("early", 4, 5, 5, 26, 2, 1, 0, 0);
    run_load("nodone", 6, 3, 2, 25, 1, 2, 0, 0);
    run_load("restart", 12, 2, 7, 40, 4, 0, 1, 0);
    run_load("clear", 3, 1, 1, 0, 0, 1, 0, 0);

    finished = 1;
    $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
    $finish;
  end

endmodule